// File: doc/BRIEF.md
# Page Program Buffer with Self-Timed Commit

This block sits between a serial memory's bus protocol engine and its nonvolatile array. A write transfer first gives it a start address, then hands it data bytes one at a time. The upper address bits select a row and stay fixed for the whole transfer. The low bits form a column counter that steps once per received byte and wraps inside the row, so a long transfer overwrites columns loaded earlier. Each column has a valid bit that records whether a byte has been loaded there.

When the protocol engine reports a STOP that falls in the slot right after a data acknowledge, the block starts a programming cycle, provided at least one byte was loaded. Busy stays high for a programmable wait time followed by one sweep over every column of the row. During the sweep, each loaded column is presented on the array write port. A STOP anywhere else, or a new start address, throws the loaded bytes away. The write-control level blocks bytes from being latched. While busy is high, every request input is ignored.

Top module: `page_prog_unit`

## Requirements
- R1: After `addr_load`, the row is `addr_in[ADDR_W-1:5]` and the column is `addr_in[4:0]`. The n-th byte received (counting from 0) is written to the row's column (start + n) mod 32. The row does not change until the next `addr_load`.
- R2: When the column wraps onto a column that already holds a byte, the later byte replaces the earlier one. Only the last value is written.
- R3: A `stop_evt` with `stop_after_ack`=1, while not busy and with at least one byte loaded, raises `busy` on the next clock. `busy` then stays high for exactly `TW_CYCLES` + 32 cycles.
- R4: Array writes happen only in the last 32 busy cycles. Busy cycle `TW_CYCLES`+1+c belongs to column c. In that cycle `arr_we` is 1 exactly when column c was loaded, and `arr_addr` = {row, c}.
- R5: A byte received while `wr_ctl`=1 is not latched and changes no array location. It still advances the column counter.
- R6: A `stop_evt` with `stop_after_ack`=0 discards all loaded bytes, and `busy` stays low. A later STOP in the acknowledge slot with no new bytes does not program.
- R7: A STOP in the acknowledge slot with no byte loaded leaves `busy` low and writes nothing.
- R8: While `busy`=1, `addr_load`, `byte_vld` and `stop_evt` have no effect. The cycle is neither restarted nor extended, and nothing is latched.
- R9: `addr_load` discards the bytes loaded before it.
- R10: After reset, `busy`=0, `arr_we`=0 and no byte is loaded.
- R11: In one cycle, `stop_evt` takes priority over `addr_load`, and `addr_load` takes priority over `byte_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load start address (new write transfer) |
| addr_in | input | ADDR_W | Start byte address |
| byte_vld | input | 1 | One received data byte is present |
| byte_data | input | DATA_W | Received data byte |
| wr_ctl | input | 1 | Write-control level; 1 blocks latching |
| stop_evt | input | 1 | STOP detected on the bus |
| stop_after_ack | input | 1 | The STOP fell in the slot after a data acknowledge |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench goes after the column wrap with a 40-byte transfer. A design that failed to wrap, or that kept the first value of a wrapped column, would leave wrong bytes in the overwritten columns. A byte pattern that alternates write-control exposes a counter that stalls on rejected bytes, because every following byte would land one column too early. A misplaced STOP followed by a STOP with no new bytes catches a buffer that is not cleared. Inputs driven in the middle of a busy cycle catch a cycle that retriggers or stretches, and bytes that leak into the next transfer. The exact busy length and the column carried by each write catch an off-by-one in the wait counter or in the sweep.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WAIT  = 2'd1,
      PH_SWEEP = 2'd2
   } phase_t;
endpackage

// File: rtl/ppu_addr_track.sv
module ppu_addr_track #(
   parameter int ADDR_W = 13,
   parameter int COL_W  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [ADDR_W-1:0]       load_addr,
   input  logic                    step,
   output logic [ADDR_W-COL_W-1:0] row,
   output logic [COL_W-1:0]        col
);
   localparam int ROW_W = ADDR_W - COL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (load) begin
         row <= load_addr[ADDR_W-1:COL_W];
         col <= load_addr[COL_W-1:0];
      end else if (step) begin
         col <= col + COL_W'(1);
      end
   end

   // R1
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(row));
endmodule

// File: rtl/ppu_page_latch.sv
module ppu_page_latch #(
   parameter int PAGE_BYTES = 32,
   parameter int DATA_W     = 8,
   parameter int COL_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [COL_W-1:0]      wr_col,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  clr,
   input  logic [COL_W-1:0]      rd_col,
   output logic [DATA_W-1:0]     rd_data,
   output logic [PAGE_BYTES-1:0] mask
);
   logic [DATA_W-1:0] slot_q [PAGE_BYTES];

   for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[c] <= '0;
            mask[c]   <= 1'b0;
         end else if (clr) begin
            mask[c]   <= 1'b0;
         end else if (wr_en && (wr_col == COL_W'(c))) begin
            slot_q[c] <= wr_data;
            mask[c]   <= 1'b1;
         end
      end
   end

   assign rd_data = slot_q[rd_col];

   // R2
   load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> mask[$past(wr_col)]);

   // R6
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0));
endmodule

// File: rtl/ppu_prog_seq.sv
module ppu_prog_seq
   import ppu_pkg::*;
#(
   parameter int PAGE_BYTES = 32,
   parameter int TW_CYCLES  = 2000000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   output logic                          busy,
   output logic                          sweep_act,
   output logic [$clog2(PAGE_BYTES)-1:0] sweep_col,
   output logic                          sweep_done
);
   localparam int COL_W = $clog2(PAGE_BYTES);
   localparam int TW_W  = $clog2(TW_CYCLES + 1);
   localparam logic [TW_W-1:0]  TW_LAST  = TW_W'(TW_CYCLES - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);

   phase_t          ph;
   logic [TW_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         wait_cnt  <= '0;
         sweep_col <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (go) begin
               ph       <= PH_WAIT;
               wait_cnt <= '0;
            end
            PH_WAIT: if (wait_cnt == TW_LAST) begin
               ph        <= PH_SWEEP;
               sweep_col <= '0;
            end else begin
               wait_cnt <= wait_cnt + TW_W'(1);
            end
            PH_SWEEP: if (sweep_col == COL_LAST) begin
               ph <= PH_IDLE;
            end else begin
               sweep_col <= sweep_col + COL_W'(1);
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (ph != PH_IDLE);
   assign sweep_act  = (ph == PH_SWEEP);
   assign sweep_done = sweep_act && (sweep_col == COL_LAST);

   // R3
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WAIT) |-> (wait_cnt < TW_W'(TW_CYCLES)));

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(sweep_done));

   // R4
   sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sweep_act) |-> (sweep_col == '0));
endmodule

// File: rtl/page_prog_unit.sv
module page_prog_unit #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int TW_CYCLES  = 2000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              wr_ctl,
   input  logic              stop_evt,
   input  logic              stop_after_ack,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);
   localparam int COL_W = $clog2(PAGE_BYTES);
   localparam int ROW_W = ADDR_W - COL_W;

   if ((1 << COL_W) != PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the column width");
   end
   if (TW_CYCLES < 1) begin : g_bad_tw
      $error("TW_CYCLES must be at least 1");
   end

   logic                  idle, stop_take, go, clr, ld, step, wr_en;
   logic [ROW_W-1:0]      row;
   logic [COL_W-1:0]      col, sweep_col;
   logic                  sweep_act, sweep_done;
   logic [PAGE_BYTES-1:0] mask;
   logic [DATA_W-1:0]     rd_data;

   assign idle      = !busy;
   assign stop_take = idle && stop_evt;
   assign go        = stop_take && stop_after_ack && (|mask);
   assign ld        = idle && !stop_evt && addr_load;
   assign step      = idle && !stop_evt && !addr_load && byte_vld;
   assign wr_en     = step && !wr_ctl;
   assign clr       = (stop_take && !go) || ld || sweep_done;

   ppu_addr_track #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_addr(addr_in),
      .step(step), .row(row), .col(col));

   ppu_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .COL_W(COL_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(col), .wr_data(byte_data),
      .clr(clr), .rd_col(sweep_col), .rd_data(rd_data), .mask(mask));

   ppu_prog_seq #(.PAGE_BYTES(PAGE_BYTES), .TW_CYCLES(TW_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .sweep_act(sweep_act),
      .sweep_col(sweep_col), .sweep_done(sweep_done));

   assign arr_we    = sweep_act && mask[sweep_col];
   assign arr_addr  = {row, sweep_col};
   assign arr_wdata = rd_data;

   // R4
   write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R3
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt && stop_after_ack));

   // R5
   wc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && byte_vld && wr_ctl && !addr_load && !stop_evt) |=> $stable(mask));

   // R6
   bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && stop_evt && !stop_after_ack) |=> (!busy && mask == '0));

   // R7
   empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && stop_evt && mask == '0) |=> !busy);

   // R8
   no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sweep_done) |=> busy);
endmodule

// File: tb/page_prog_unit_test.sv
`timescale 1ns/1ps
module page_prog_unit_test;
   localparam int AW = 8;
   localparam int PB = 32;
   localparam int TW = 20;
   localparam int NMEM = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_load = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          byte_vld = 1'b0;
   logic [7:0]    byte_data = '0;
   logic          wr_ctl = 1'b0;
   logic          stop_evt = 1'b0;
   logic          stop_after_ack = 1'b0;
   logic          busy, arr_we;
   logic [AW-1:0] arr_addr;
   logic [7:0]    arr_wdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem  [NMEM];
   logic [7:0] expm [NMEM];
   logic [7:0] pend [PB];
   logic       pv   [PB];
   int m_row, m_col, bidx;

   always #2.5 clk = ~clk;

   page_prog_unit #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB), .TW_CYCLES(TW)) uut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_vld(byte_vld), .byte_data(byte_data), .wr_ctl(wr_ctl),
      .stop_evt(stop_evt), .stop_after_ack(stop_after_ack), .busy(busy),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // write-port monitor (R4): column carried by each busy cycle
   always @(negedge clk) begin
      if (busy) bidx++;
      else bidx = 0;
      if (arr_we) begin
         check(busy && bidx > TW && int'(arr_addr[4:0]) == bidx - TW - 1,
               "R4 write slot", int'(arr_addr[4:0]), bidx - TW - 1);
         mem[arr_addr] = arr_wdata;
      end
   end

   task automatic begin_txn(input int a);
      @(negedge clk); addr_load = 1'b1; addr_in = AW'(a);
      @(negedge clk); addr_load = 1'b0;
      m_row = a >> 5; m_col = a & 31;
      for (int i = 0; i < PB; i++) pv[i] = 1'b0;
   endtask

   task automatic send_byte(input int v, input bit wc);
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'(v); wr_ctl = wc;
      @(negedge clk); byte_vld = 1'b0; wr_ctl = 1'b0;
      if (!wc) begin pend[m_col] = 8'(v); pv[m_col] = 1'b1; end
      m_col = (m_col + 1) % PB;
   endtask

   task automatic end_txn(input bit good, input bit interfere, input string tag);
      bit prog = 1'b0;
      int nb = 0;
      int bad = 0;
      int exp_nb;
      for (int i = 0; i < PB; i++) if (pv[i]) prog = good;
      @(negedge clk); stop_evt = 1'b1; stop_after_ack = good;
      @(negedge clk); stop_evt = 1'b0; stop_after_ack = 1'b0;
      for (int i = 0; i < TW + 60; i++) begin
         if (busy) nb++;
         if (interfere && i == 3) begin
            addr_load = 1'b1; addr_in = 8'h11; byte_vld = 1'b1; byte_data = 8'h5A;
            stop_evt = 1'b1; stop_after_ack = 1'b1;
         end
         if (interfere && i == 4) begin
            addr_load = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0; stop_after_ack = 1'b0;
         end
         @(negedge clk);
      end
      exp_nb = prog ? TW + 32 : 0;
      check(nb == exp_nb, {tag, " busy length"}, nb, exp_nb);
      if (prog)
         for (int i = 0; i < PB; i++) if (pv[i]) expm[m_row * PB + i] = pend[i];
      for (int i = 0; i < PB; i++) pv[i] = 1'b0;
      for (int i = 0; i < NMEM; i++) if (mem[i] !== expm[i]) bad++;
      check(bad == 0, {tag, " array contents"}, bad, 0);
   endtask

   initial begin
      for (int i = 0; i < NMEM; i++) begin mem[i] = 8'hFF; expm[i] = 8'hFF; end
      for (int i = 0; i < PB; i++) begin pv[i] = 1'b0; pend[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R10 reset state
      check(busy == 1'b0 && arr_we == 1'b0, "R10 reset outputs", int'(busy), 0);
      rst_n = 1'b1;
      m_row = 0; m_col = 0;
      end_txn(1'b1, 1'b0, "R10 empty after reset");

      // R1 R3 R4 full row from column 0
      begin_txn(32 * 2);
      for (int k = 0; k < 32; k++) send_byte((k * 13 + 7) & 255, 1'b0);
      end_txn(1'b1, 1'b0, "R1 R3 full row");

      // R1 single byte mid-row
      begin_txn(32 * 5 + 17);
      send_byte(8'hA5, 1'b0);
      end_txn(1'b1, 1'b0, "R1 single byte");

      // R2 wrap: 40 bytes from column 5
      begin_txn(32 * 3 + 5);
      for (int k = 0; k < 40; k++) send_byte((k * 29 + 3) & 255, 1'b0);
      end_txn(1'b1, 1'b0, "R2 wrap overwrite");

      // R5 alternating write-control
      begin_txn(32 * 6 + 9);
      for (int k = 0; k < 10; k++) send_byte((k * 17 + 1) & 255, k[0]);
      end_txn(1'b1, 1'b0, "R5 alternating wc");

      // R5 R7 all bytes blocked leaves nothing to program
      begin_txn(32 * 1);
      for (int k = 0; k < 6; k++) send_byte(k + 40, 1'b1);
      end_txn(1'b1, 1'b0, "R5 R7 all blocked");

      // R6 misplaced stop discards, then empty good stop
      begin_txn(32 * 4 + 2);
      for (int k = 0; k < 4; k++) send_byte(k + 90, 1'b0);
      end_txn(1'b0, 1'b0, "R6 misplaced stop");
      end_txn(1'b1, 1'b0, "R6 stop after discard");

      // R9 address load discards earlier bytes
      begin_txn(32 * 7);
      for (int k = 0; k < 3; k++) send_byte(k + 200, 1'b0);
      begin_txn(32 * 0 + 30);
      for (int k = 0; k < 4; k++) send_byte(k + 60, 1'b0);
      end_txn(1'b1, 1'b0, "R9 reload discard");

      // R8 inputs while busy are ignored
      begin_txn(32 * 7 + 12);
      for (int k = 0; k < 3; k++) send_byte(k + 150, 1'b0);
      end_txn(1'b1, 1'b1, "R8 busy interference");
      end_txn(1'b1, 1'b0, "R8 nothing leaked");

      // R11 stop wins over address load and byte in the same cycle
      begin_txn(32 * 2 + 20);
      send_byte(8'h3C, 1'b0);
      @(negedge clk); stop_evt = 1'b1; stop_after_ack = 1'b0; addr_load = 1'b1;
      addr_in = 8'h00; byte_vld = 1'b1; byte_data = 8'h77;
      @(negedge clk); stop_evt = 1'b0; addr_load = 1'b0; byte_vld = 1'b0;
      for (int i = 0; i < PB; i++) pv[i] = 1'b0;
      end_txn(1'b1, 1'b0, "R11 stop priority");

      // R11 address load wins over byte
      @(negedge clk); addr_load = 1'b1; addr_in = 8'(32 * 5 + 3); byte_vld = 1'b1; byte_data = 8'h99;
      @(negedge clk); addr_load = 1'b0; byte_vld = 1'b0;
      m_row = 5; m_col = 3;
      for (int i = 0; i < PB; i++) pv[i] = 1'b0;
      send_byte(8'h42, 1'b0);
      end_txn(1'b1, 1'b0, "R11 load over byte");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule